// File: doc/BRIEF.md
# Reserving Set-Associative Tag Store

This block is the tag half of a read-only cache. A requester presents a line address (the byte address with the in-line offset already dropped). One cycle later the block answers with a status and the index of the line it chose. The status is one of four: a plain hit, a hit on a line that was claimed but still waits for its data, a miss, or a refusal because no line in the set could be given up. Each line is invalid, reserved or valid. A separate fill port, addressed by line index, completes a line once the lower memory level returns its data.

Two run-time controls shape the behaviour. The first chooses when a line is claimed. In allocate-at-miss mode the victim is claimed and marked reserved as soon as the miss is seen. In allocate-at-fill mode a miss only names the victim, and the fill port installs the tag later. The second control picks the replacement order: least recently used, based on the last-access stamp, or first in first out, based on the allocation stamp. A flash-invalidate input empties the whole store in one cycle. Three counters track lookups, misses and pending hits.

Top module: `tag_reserve_array`

## Requirements
- R1: After reset, resp_valid is 0, all three counters are 0 and every line is invalid, so the first lookup to any set misses.
- R2: For a line address, the set is its low log2(NUM_SETS) bits and the tag is the remaining upper bits. The line index is set*NUM_WAYS+way.
- R3: A lookup accepted on a clock edge is answered at the next edge: resp_valid is 1 for exactly one cycle per lookup. resp_status encodes 0=hit, 1=hit on reserved line, 2=miss, 3=reservation failure. resp_idx lies in the looked-up set.
- R4: A lookup whose tag matches a valid line in its set returns status 0 with that line's index and refreshes the line's last-access stamp. When several lines match, the lowest way wins.
- R5: A lookup whose tag matches a reserved line returns status 1, increments pending_cnt and refreshes the last-access stamp.
- R6: In allocate-at-miss mode, a miss loads the victim with the new tag, marks it reserved and stamps both its allocation time and its last-access time.
- R7: In allocate-at-miss mode, a fill to a reserved line makes it valid. A fill to a line that is not reserved is ignored.
- R8: In allocate-at-fill mode, a miss leaves every line unchanged. A fill writes fill_tag into line fill_idx, makes it valid and stamps it.
- R9: The victim is the lowest invalid way. If no way is invalid, it is the valid way with the smallest stamp: the last-access stamp when repl_fifo=0, the allocation stamp when repl_fifo=1. Ties go to the lowest way. A reserved way is never chosen.
- R10: When every way of the set is reserved and none matches, the status is 3, resp_idx is way 0 of that set, and no line changes.
- R11: access_cnt grows by one per lookup. miss_cnt grows by one per status 2 or 3. pending_cnt grows by one per status 1. All three wrap at 2^CNT_W.
- R12: flush makes every line invalid at the next edge. A lookup in the same cycle as the flush is answered from the contents before the flush.
- R13: When a lookup and a fill arrive in the same cycle, the lookup sees the state before the fill. A lookup that meets a reserved line being filled returns status 1, and the line is valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_valid | input | 1 | A lookup is presented this cycle |
| lookup_line | input | ADDR_W-log2(LINE_BYTES) | Line address to look up |
| repl_fifo | input | 1 | 0: least recently used victim, 1: oldest allocation victim |
| alloc_at_miss | input | 1 | 1: claim victim at miss, 0: install at fill |
| fill_valid | input | 1 | A fill is presented this cycle |
| fill_idx | input | log2(NUM_SETS*NUM_WAYS) | Line index the fill targets |
| fill_tag | input | tag width | Tag written by a fill in allocate-at-fill mode |
| flush | input | 1 | Invalidate every line |
| resp_valid | output | 1 | Response present |
| resp_status | output | 2 | Lookup outcome code |
| resp_idx | output | log2(NUM_SETS*NUM_WAYS) | Line index selected |
| access_cnt | output | CNT_W | Lookups seen |
| miss_cnt | output | CNT_W | Misses and reservation failures |
| pending_cnt | output | CNT_W | Hits on reserved lines |

## Verification
Two functions can act in the same cycle: a lookup and a fill, and also a lookup and a flush. The bench provokes both. It fills a reserved line in the very cycle that a lookup targets it, and it flushes while a lookup on a valid line is in flight. The expected answer is the one built from the state before that edge: a pending hit that later reads back as a plain hit, and a hit followed by a miss on the next lookup. A randomized stretch then mixes lookups, fills to arbitrary indices, flushes and mode changes, so both collisions recur under both replacement orders and both allocation modes.

// File: rtl/tra_pkg.sv
package tra_pkg;

    typedef enum logic [1:0] {
        LS_INVALID  = 2'd0,
        LS_RESERVED = 2'd1,
        LS_VALID    = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        ST_HIT     = 2'd0,
        ST_HIT_RSV = 2'd1,
        ST_MISS    = 2'd2,
        ST_FAIL    = 2'd3
    } lookup_status_e;

endpackage

// File: rtl/tra_addr_split.sv
module tra_addr_split #(
    parameter int LADDR_W = 28,
    parameter int SET_B   = 2,
    localparam int TAG_W  = LADDR_W - SET_B
) (
    input  logic [LADDR_W-1:0] line_addr,
    output logic [SET_B-1:0]   set_idx,
    output logic [TAG_W-1:0]   tag
);

    assign set_idx = line_addr[SET_B-1:0];
    assign tag     = line_addr[LADDR_W-1:SET_B];

endmodule

// File: rtl/tra_set_probe.sv
module tra_set_probe
    import tra_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 26,
    localparam int WAY_B   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0][1:0]       way_state,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]               probe_tag,
    output logic                           hit,
    output logic [WAY_B-1:0]               hit_way,
    output logic                           hit_reserved
);

    logic [NUM_WAYS-1:0] match;

    generate
        for (genvar g = 0; g < NUM_WAYS; g++) begin : g_match
            assign match[g] = (way_state[g] != LS_INVALID) && (way_tag[g] == probe_tag);
        end
    endgenerate

    always_comb begin
        logic taken;
        taken   = 1'b0;
        hit_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (match[w] && !taken) begin
                taken   = 1'b1;
                hit_way = WAY_B'(w);
            end
        end
        hit          = |match;
        hit_reserved = (way_state[hit_way] == LS_RESERVED);
    end

endmodule

// File: rtl/tra_victim_sel.sv
module tra_victim_sel
    import tra_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int TS_W     = 16,
    localparam int WAY_B   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0][1:0]      way_state,
    input  logic [NUM_WAYS-1:0][TS_W-1:0] way_last,
    input  logic [NUM_WAYS-1:0][TS_W-1:0] way_alloc,
    input  logic                          use_fifo,
    output logic                          found,
    output logic [WAY_B-1:0]              victim_way
);

    logic [NUM_WAYS-1:0]           is_free;
    logic [NUM_WAYS-1:0]           is_ready;
    logic [NUM_WAYS-1:0][TS_W-1:0] age_key;

    generate
        for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
            assign is_free[g]  = (way_state[g] == LS_INVALID);
            assign is_ready[g] = (way_state[g] == LS_VALID);
            assign age_key[g]  = use_fifo ? way_alloc[g] : way_last[g];
        end
    endgenerate

    always_comb begin
        logic            got_free;
        logic            got_old;
        logic [TS_W-1:0] best;
        got_free   = 1'b0;
        got_old    = 1'b0;
        best       = '0;
        victim_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (is_free[w] && !got_free) begin
                got_free   = 1'b1;
                victim_way = WAY_B'(w);
            end
        end
        if (!got_free) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (is_ready[w] && (!got_old || age_key[w] < best)) begin
                    got_old    = 1'b1;
                    best       = age_key[w];
                    victim_way = WAY_B'(w);
                end
            end
        end
        found = got_free || got_old;
    end

endmodule

// File: rtl/tag_reserve_array.sv
module tag_reserve_array
    import tra_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int NUM_SETS   = 4,
    parameter int NUM_WAYS   = 4,
    parameter int TS_W       = 16,
    parameter int CNT_W      = 16,
    localparam int OFF_B     = $clog2(LINE_BYTES),
    localparam int SET_B     = $clog2(NUM_SETS),
    localparam int WAY_B     = $clog2(NUM_WAYS),
    localparam int LADDR_W   = ADDR_W - OFF_B,
    localparam int TAG_W     = LADDR_W - SET_B,
    localparam int IDX_B     = SET_B + WAY_B,
    localparam int LINES     = NUM_SETS * NUM_WAYS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lookup_valid,
    input  logic [LADDR_W-1:0] lookup_line,
    input  logic               repl_fifo,
    input  logic               alloc_at_miss,
    input  logic               fill_valid,
    input  logic [IDX_B-1:0]   fill_idx,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic               flush,
    output logic               resp_valid,
    output logic [1:0]         resp_status,
    output logic [IDX_B-1:0]   resp_idx,
    output logic [CNT_W-1:0]   access_cnt,
    output logic [CNT_W-1:0]   miss_cnt,
    output logic [CNT_W-1:0]   pending_cnt
);

    typedef struct packed {
        logic [LINES-1:0][1:0]       lst;
        logic [LINES-1:0][TAG_W-1:0] ltag;
        logic [LINES-1:0][TS_W-1:0]  llast;
        logic [LINES-1:0][TS_W-1:0]  lalloc;
        logic [TS_W-1:0]             stamp;
        logic                        rv;
        logic [1:0]                  rstat;
        logic [IDX_B-1:0]            ridx;
        logic [CNT_W-1:0]            nacc;
        logic [CNT_W-1:0]            nmiss;
        logic [CNT_W-1:0]            npend;
    } state_t;

    state_t state_d, state_q;

    logic [SET_B-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;

    tra_addr_split #(
        .LADDR_W (LADDR_W),
        .SET_B   (SET_B)
    ) u_split (
        .line_addr (lookup_line),
        .set_idx   (lk_set),
        .tag       (lk_tag)
    );

    // view of the addressed set
    logic [NUM_WAYS-1:0][1:0]       set_st_d;
    logic [NUM_WAYS-1:0][TAG_W-1:0] set_tag_d;
    logic [NUM_WAYS-1:0][TS_W-1:0]  set_last_d;
    logic [NUM_WAYS-1:0][TS_W-1:0]  set_alloc_d;

    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            set_st_d[w]    = state_q.lst[{lk_set, WAY_B'(w)}];
            set_tag_d[w]   = state_q.ltag[{lk_set, WAY_B'(w)}];
            set_last_d[w]  = state_q.llast[{lk_set, WAY_B'(w)}];
            set_alloc_d[w] = state_q.lalloc[{lk_set, WAY_B'(w)}];
        end
    end

    logic             pr_hit;
    logic [WAY_B-1:0] pr_way;
    logic             pr_rsv;

    tra_set_probe #(
        .NUM_WAYS (NUM_WAYS),
        .TAG_W    (TAG_W)
    ) u_probe (
        .way_state    (set_st_d),
        .way_tag      (set_tag_d),
        .probe_tag    (lk_tag),
        .hit          (pr_hit),
        .hit_way      (pr_way),
        .hit_reserved (pr_rsv)
    );

    logic             vc_found;
    logic [WAY_B-1:0] vc_way;

    tra_victim_sel #(
        .NUM_WAYS (NUM_WAYS),
        .TS_W     (TS_W)
    ) u_victim (
        .way_state  (set_st_d),
        .way_last   (set_last_d),
        .way_alloc  (set_alloc_d),
        .use_fifo   (repl_fifo),
        .found      (vc_found),
        .victim_way (vc_way)
    );

    always_comb begin
        state_d    = state_q;
        state_d.rv = lookup_valid;

        if (lookup_valid) begin
            state_d.stamp = state_q.stamp + TS_W'(1);
            state_d.nacc  = state_q.nacc + CNT_W'(1);
            if (pr_hit) begin
                state_d.ridx = {lk_set, pr_way};
                state_d.llast[{lk_set, pr_way}] = state_q.stamp;
                if (pr_rsv) begin
                    state_d.rstat = ST_HIT_RSV;
                    state_d.npend = state_q.npend + CNT_W'(1);
                end else begin
                    state_d.rstat = ST_HIT;
                end
            end else if (!vc_found) begin
                state_d.rstat = ST_FAIL;
                state_d.ridx  = {lk_set, WAY_B'(0)};
                state_d.nmiss = state_q.nmiss + CNT_W'(1);
            end else begin
                state_d.rstat = ST_MISS;
                state_d.ridx  = {lk_set, vc_way};
                state_d.nmiss = state_q.nmiss + CNT_W'(1);
                if (alloc_at_miss) begin
                    state_d.lst[{lk_set, vc_way}]    = LS_RESERVED;
                    state_d.ltag[{lk_set, vc_way}]   = lk_tag;
                    state_d.llast[{lk_set, vc_way}]  = state_q.stamp;
                    state_d.lalloc[{lk_set, vc_way}] = state_q.stamp;
                end
            end
        end

        // fill is judged on the state before this edge
        if (fill_valid) begin
            if (alloc_at_miss) begin
                if (state_q.lst[fill_idx] == LS_RESERVED) begin
                    state_d.lst[fill_idx] = LS_VALID;
                end
            end else begin
                state_d.lst[fill_idx]    = LS_VALID;
                state_d.ltag[fill_idx]   = fill_tag;
                state_d.llast[fill_idx]  = state_q.stamp;
                state_d.lalloc[fill_idx] = state_q.stamp;
            end
        end

        if (flush) begin
            for (int i = 0; i < LINES; i++) begin
                state_d.lst[i] = LS_INVALID;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign resp_valid  = state_q.rv;
    assign resp_status = state_q.rstat;
    assign resp_idx    = state_q.ridx;
    assign access_cnt  = state_q.nacc;
    assign miss_cnt    = state_q.nmiss;
    assign pending_cnt = state_q.npend;

endmodule

module tra_checker #(
    parameter int SET_B = 2,
    parameter int WAY_B = 2,
    parameter int CNT_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lookup_valid,
    input logic [SET_B-1:0]       lookup_set,
    input logic                   flush,
    input logic                   resp_valid,
    input logic [1:0]             resp_status,
    input logic [SET_B+WAY_B-1:0] resp_idx,
    input logic [CNT_W-1:0]       access_cnt,
    input logic [CNT_W-1:0]       miss_cnt,
    input logic [CNT_W-1:0]       pending_cnt
);

    a_r3_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> resp_valid);

    a_r3_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> !resp_valid);

    a_r3_idx_in_set: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> resp_idx[SET_B+WAY_B-1:WAY_B] == $past(lookup_set));

    a_r11_access_step: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> access_cnt == CNT_W'($past(access_cnt) + CNT_W'(1)));

    a_r11_access_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> $stable(access_cnt));

    a_r11_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status[1]) |-> miss_cnt == CNT_W'($past(miss_cnt) + CNT_W'(1)));

    a_r11_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_valid && resp_status[1]) |-> $stable(miss_cnt));

    a_r5_pending_step: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status == 2'd1) |-> pending_cnt == CNT_W'($past(pending_cnt) + CNT_W'(1)));

    a_r5_pending_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_valid && resp_status == 2'd1) |-> $stable(pending_cnt));

    a_r10_fail_way0: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_status == 2'd3) |-> resp_idx[WAY_B-1:0] == '0);

    a_r12_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush ##1 lookup_valid |=> resp_status == 2'd2);

endmodule

bind tag_reserve_array tra_checker #(
    .SET_B (SET_B),
    .WAY_B (WAY_B),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lookup_valid (lookup_valid),
    .lookup_set   (lookup_line[SET_B-1:0]),
    .flush        (flush),
    .resp_valid   (resp_valid),
    .resp_status  (resp_status),
    .resp_idx     (resp_idx),
    .access_cnt   (access_cnt),
    .miss_cnt     (miss_cnt),
    .pending_cnt  (pending_cnt)
);

// File: tb/tb_tag_reserve_array.sv
module tb_tag_reserve_array;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int LINE_BYTES = 16;
    localparam int NS         = 4;
    localparam int NW         = 4;
    localparam int TS_W       = 16;
    localparam int CNT_W      = 16;
    localparam int SET_B      = 2;
    localparam int LADDR_W    = 28;
    localparam int TAG_W      = 26;
    localparam int IDX_B      = 4;
    localparam int LINES      = NS * NW;
    localparam int CMASK      = (1 << CNT_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               lookup_valid = 1'b0;
    logic [LADDR_W-1:0] lookup_line = '0;
    logic               repl_fifo = 1'b0;
    logic               alloc_at_miss = 1'b1;
    logic               fill_valid = 1'b0;
    logic [IDX_B-1:0]   fill_idx = '0;
    logic [TAG_W-1:0]   fill_tag = '0;
    logic               flush = 1'b0;
    logic               resp_valid;
    logic [1:0]         resp_status;
    logic [IDX_B-1:0]   resp_idx;
    logic [CNT_W-1:0]   access_cnt;
    logic [CNT_W-1:0]   miss_cnt;
    logic [CNT_W-1:0]   pending_cnt;

    tag_reserve_array #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES),
        .NUM_SETS   (NS),
        .NUM_WAYS   (NW),
        .TS_W       (TS_W),
        .CNT_W      (CNT_W)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .lookup_valid  (lookup_valid),
        .lookup_line   (lookup_line),
        .repl_fifo     (repl_fifo),
        .alloc_at_miss (alloc_at_miss),
        .fill_valid    (fill_valid),
        .fill_idx      (fill_idx),
        .fill_tag      (fill_tag),
        .flush         (flush),
        .resp_valid    (resp_valid),
        .resp_status   (resp_status),
        .resp_idx      (resp_idx),
        .access_cnt    (access_cnt),
        .miss_cnt      (miss_cnt),
        .pending_cnt   (pending_cnt)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    n_checks = 0;
    int    n_err    = 0;
    string cur_req  = "R1";
    bit    done     = 1'b0;

    // behavioural reference: 0 invalid, 1 reserved, 2 valid
    int m_st[LINES];
    int m_tag[LINES];
    int m_last[LINES];
    int m_alloc[LINES];
    int m_stamp;
    bit e_rv;
    int e_stat, e_idx, e_acc, e_miss, e_pend;

    function automatic int mk(int tag, int set);
        return (tag << SET_B) | set;
    endfunction

    task automatic chk(bit ok, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < LINES; i++) begin
            m_st[i] = 0; m_tag[i] = 0; m_last[i] = 0; m_alloc[i] = 0;
        end
        m_stamp = 0; e_rv = 0; e_stat = 0; e_idx = 0;
        e_acc = 0; e_miss = 0; e_pend = 0;
    endtask

    task automatic model_step();
        int pre_fill = m_st[fill_idx];
        int stamp0   = m_stamp;
        e_rv = lookup_valid;
        if (lookup_valid) begin
            int set = int'(lookup_line) % NS;
            int tag = int'(lookup_line) >> SET_B;
            int hw  = -1;
            int vw  = -1;
            int bk  = 0;
            e_acc = (e_acc + 1) & CMASK;
            for (int w = 0; w < NW; w++)
                if (hw < 0 && m_st[set*NW+w] != 0 && m_tag[set*NW+w] == tag) hw = w;
            if (hw >= 0) begin
                e_idx = set*NW + hw;
                m_last[e_idx] = stamp0;
                if (m_st[e_idx] == 1) begin
                    e_stat = 1; e_pend = (e_pend + 1) & CMASK;
                end else e_stat = 0;
            end else begin
                for (int w = 0; w < NW; w++)
                    if (vw < 0 && m_st[set*NW+w] == 0) vw = w;
                if (vw < 0) begin
                    for (int w = 0; w < NW; w++) begin
                        int k = repl_fifo ? m_alloc[set*NW+w] : m_last[set*NW+w];
                        if (m_st[set*NW+w] == 2 && (vw < 0 || k < bk)) begin
                            vw = w; bk = k;
                        end
                    end
                end
                e_miss = (e_miss + 1) & CMASK;
                if (vw < 0) begin
                    e_stat = 3; e_idx = set*NW;
                end else begin
                    e_stat = 2; e_idx = set*NW + vw;
                    if (alloc_at_miss) begin
                        m_st[e_idx] = 1; m_tag[e_idx] = tag;
                        m_last[e_idx] = stamp0; m_alloc[e_idx] = stamp0;
                    end
                end
            end
            m_stamp = (m_stamp + 1) & ((1 << TS_W) - 1);
        end
        if (fill_valid) begin
            if (alloc_at_miss) begin
                if (pre_fill == 1) m_st[fill_idx] = 2;
            end else begin
                m_st[fill_idx] = 2; m_tag[fill_idx] = int'(fill_tag);
                m_last[fill_idx] = stamp0; m_alloc[fill_idx] = stamp0;
            end
        end
        if (flush) for (int i = 0; i < LINES; i++) m_st[i] = 0;
    endtask

    task automatic compare();
        chk(resp_valid == e_rv, "resp_valid", int'(resp_valid), int'(e_rv));
        if (e_rv) begin
            chk(int'(resp_status) == e_stat, "resp_status", int'(resp_status), e_stat);
            chk(int'(resp_idx) == e_idx, "resp_idx", int'(resp_idx), e_idx);
        end
        chk(int'(access_cnt) == e_acc, "access_cnt", int'(access_cnt), e_acc);
        chk(int'(miss_cnt) == e_miss, "miss_cnt", int'(miss_cnt), e_miss);
        chk(int'(pending_cnt) == e_pend, "pending_cnt", int'(pending_cnt), e_pend);
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        #1;
        compare();
        lookup_valid = 1'b0;
        fill_valid   = 1'b0;
        flush        = 1'b0;
    endtask

    task automatic look(int line);
        lookup_valid = 1'b1;
        lookup_line  = LADDR_W'(line);
        cyc();
    endtask

    task automatic fill_only(int idx);
        fill_valid = 1'b1;
        fill_idx   = IDX_B'(idx);
        cyc();
    endtask

    task automatic expect_resp(int st, int idx);
        chk(resp_valid == 1'b1, "direct resp_valid", int'(resp_valid), 1);
        chk(int'(resp_status) == st, "direct resp_status", int'(resp_status), st);
        chk(int'(resp_idx) == idx, "direct resp_idx", int'(resp_idx), idx);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        cur_req = "R1";
        chk(resp_valid == 1'b0, "reset resp_valid", int'(resp_valid), 0);
        chk(access_cnt == 0 && miss_cnt == 0 && pending_cnt == 0, "reset counters",
            int'(access_cnt) + int'(miss_cnt) + int'(pending_cnt), 0);

        cur_req = "R1 R6 R9 first miss";
        look(mk(1, 0)); expect_resp(2, 0);
        cur_req = "R5 R2 reserved hit";
        look(mk(1, 0)); expect_resp(1, 0);
        cur_req = "R7 R4 fill then hit";
        fill_only(0);
        look(mk(1, 0)); expect_resp(0, 0);
        cur_req = "R7 fill on invalid line ignored";
        fill_only(1);
        look(mk(0, 0)); expect_resp(2, 1);
        cur_req = "R2 other set";
        look(mk(1, 1)); expect_resp(2, 4);

        cur_req = "R10 all reserved";
        look(mk(2, 1)); look(mk(3, 1)); look(mk(4, 1)); expect_resp(2, 7);
        look(mk(5, 1)); expect_resp(3, 4);
        look(mk(5, 1)); expect_resp(3, 4);
        chk(int'(miss_cnt) == 8, "R11 miss count", int'(miss_cnt), 8);

        cur_req = "R13 fill and lookup same cycle";
        fill_valid = 1'b1; fill_idx = IDX_B'(5);
        look(mk(2, 1)); expect_resp(1, 5);
        look(mk(2, 1)); expect_resp(0, 5);

        cur_req = "R9 least recently used";
        for (int t = 1; t <= 4; t++) look(mk(t, 2));
        for (int i = 8; i < 12; i++) fill_only(i);
        look(mk(1, 2)); expect_resp(0, 8);
        look(mk(9, 2)); expect_resp(2, 9);
        fill_only(9);

        cur_req = "R9 oldest allocation";
        repl_fifo = 1'b1;
        for (int t = 1; t <= 4; t++) look(mk(t, 3));
        for (int i = 12; i < 16; i++) fill_only(i);
        look(mk(1, 3)); expect_resp(0, 12);
        look(mk(9, 3)); expect_resp(2, 12);
        repl_fifo = 1'b0;

        cur_req = "R12 flush with lookup";
        flush = 1'b1;
        look(mk(2, 1)); expect_resp(0, 5);
        look(mk(2, 1)); expect_resp(2, 4);

        cur_req = "R8 install at fill";
        alloc_at_miss = 1'b0;
        look(mk(7, 0)); expect_resp(2, 0);
        look(mk(7, 0)); expect_resp(2, 0);
        fill_tag = TAG_W'(7);
        fill_only(2);
        look(mk(7, 0)); expect_resp(0, 2);

        cur_req = "R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 R13 random";
        for (int c = 0; c < 3000; c++) begin
            if (c % 500 == 0) alloc_at_miss = ($urandom % 4) != 0;
            if (c % 250 == 0) repl_fifo = $urandom % 2;
            lookup_valid = ($urandom % 4) != 0;
            lookup_line  = LADDR_W'(mk(int'($urandom % 7), int'($urandom % NS)));
            fill_valid   = ($urandom % 3) == 0;
            fill_idx     = IDX_B'($urandom % LINES);
            fill_tag     = TAG_W'($urandom % 7);
            flush        = ($urandom % 97) == 0;
            cyc();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule